// File: doc/BRIEF.md
# Reset Sequencer with Pin Stretch

This block generates the internal reset of a microcontroller-style system. Four things can request a reset: a power-on input, a shared open-drain reset pin, a clock-loss flag from an oscillator monitor, and a software watchdog timeout. Every accepted request starts a fixed sequence timed in system clock cycles. In the first phase the block pulls the reset pin low. In the second phase it lets the pin go and waits. The internal reset is released only when the second phase has finished and the pin reads high.

An external device that keeps the pin low can therefore hold the whole system in reset for as long as it needs. The pin level passes through a two-flop synchroniser before the sequencer uses it. A cause register keeps one flag per reset source. Software clears these flags by writing ones. Power-on reset sets its own flag and wipes the others.

Top module: `rstseq_top`

## Requirements
- R1: While `por_ni` is low, `rst_o` and `pin_drive_o` are both 1.
- R2: If the pin is not held low from outside, `rst_o` stays 1 for exactly 768 rising clock edges. The count starts at the release of `por_ni`, or at the edge that accepts a request. `rst_o` is 0 after the 768th edge.
- R3: `pin_drive_o` is 1 for the first 512 of those edges and 0 from the 512th edge on. `rst_o` stays 1 for the remaining 256 edges.
- R4: If the synchronised pin is low when the wait phase ends, `rst_o` stays 1 until the pin reads high. It falls on the third rising edge after the pin goes high.
- R5: A high `wdog_i` sampled at a rising edge starts the sequence at that edge (`rst_o` becomes 1). It also sets cause bit 3.
- R6: A high `cmon_fail_i` starts the sequence and sets cause bit 2, but only when `osc_en_i` is 1 and `full_stop_i` is 0. In every other case it is ignored: `rst_o` stays 0 and cause is unchanged.
- R7: A low pin level while the block is idle starts the sequence on the third rising edge after the pin falls, and sets cause bit 1. A low pin during a running sequence is not a new request.
- R8: A watchdog or clock-monitor request during a running sequence restarts it at cycle zero, so `pin_drive_o` stays 1 for 512 more edges.
- R9: An edge with `clr_we_i` high clears each cause bit whose `clr_mask_i` bit is 1. Bits with mask 0 are untouched. If a bit is set and cleared in the same cycle, the set wins.
- R10: Power-on reset sets `cause_o` to 4'b0001, with bit 0 for power-on, which clears the other three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_i | input | 1 | Level read back from the reset pin |
| pin_drive_o | output | 1 | Open-drain enable, 1 pulls the pin low |
| wdog_i | input | 1 | Watchdog timeout request |
| cmon_fail_i | input | 1 | Clock-loss flag from the oscillator monitor |
| osc_en_i | input | 1 | External oscillator enabled |
| full_stop_i | input | 1 | Full stop mode, clock monitor off |
| clr_we_i | input | 1 | Write strobe for clearing cause flags |
| clr_mask_i | input | 4 | Write-one-to-clear mask, bit order as in cause_o |
| cause_o | output | 4 | Flags: 0 power-on, 1 pin, 2 clock monitor, 3 watchdog |
| rst_o | output | 1 | Internal reset, active high |

## Verification
Each source is tried on its own to show which request sets which flag:
- a one-cycle watchdog pulse;
- a clock-loss flag under all three gating combinations, which separates an accepted request from an ignored one;
- pin pulses of one and of three cycles.

Exact edge counts after power-on and after a watchdog request pin down where the drive phase ends and where the wait phase ends. A clock-loss request in the middle of a sequence tells a restart from a sequence that simply runs on. A pin held low for a thousand cycles tells stretching apart from re-triggering, because the reset must drop three edges after the pin is let go and not a full sequence later.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_WAIT  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    localparam int NSRC     = 4;
    localparam int SRC_POR  = 0;
    localparam int SRC_PIN  = 1;
    localparam int SRC_CMON = 2;
    localparam int SRC_WDOG = 3;

    typedef struct packed {
        logic wdog;
        logic cmon;
        logic pin;
    } req_t;
endpackage

// File: rtl/rstseq_pin_sync.sv
module rstseq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic pin_i,
    output logic pin_hi_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) sync_q <= '{chain: '1};
        else         sync_q <= sync_d;
    end

    assign pin_hi_o = sync_q.chain[STAGES-1];
endmodule

// File: rtl/rstseq_req.sv
module rstseq_req
    import rstseq_pkg::*;
(
    input  logic idle_i,
    input  logic pin_hi_i,
    input  logic wdog_i,
    input  logic cmon_fail_i,
    input  logic osc_en_i,
    input  logic full_stop_i,
    output req_t req_o,
    output logic start_o
);
    logic cmon_live;

    always_comb begin
        cmon_live    = osc_en_i & ~full_stop_i;
        req_o.wdog   = wdog_i;
        req_o.cmon   = cmon_fail_i & cmon_live;
        req_o.pin    = idle_i & ~pin_hi_i;
        start_o      = req_o.wdog | req_o.cmon | req_o.pin;
    end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC = 512,
    parameter int WAIT_CYC  = 256
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic start_i,
    input  logic pin_hi_i,
    output logic idle_o,
    output logic drive_o,
    output logic rst_o
);
    localparam int MAXC = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DRIVE_LAST = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_CYC - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: ;
            PH_DRIVE: begin
                if (seq_q.cnt == DRIVE_LAST) begin
                    seq_d.ph  = PH_WAIT;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            PH_WAIT: begin
                if (seq_q.cnt == WAIT_LAST) begin
                    seq_d.ph  = pin_hi_i ? PH_IDLE : PH_HOLD;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            PH_HOLD: begin
                if (pin_hi_i) seq_d.ph = PH_IDLE;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
        if (start_i) begin
            seq_d.ph  = PH_DRIVE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) seq_q <= '{ph: PH_DRIVE, cnt: '0};
        else         seq_q <= seq_d;
    end

    assign idle_o  = (seq_q.ph == PH_IDLE);
    assign drive_o = (seq_q.ph == PH_DRIVE);
    assign rst_o   = ~idle_o;

    AST_STRETCH_HOLDS: assert property (@(posedge clk_i) disable iff (!por_ni)
        (rst_o && !pin_hi_i) |=> rst_o); // R4
    AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!por_ni)
        start_i |=> (drive_o && seq_q.cnt == '0)); // R8
    AST_DRIVE_END_IN_RESET: assert property (@(posedge clk_i) disable iff (!por_ni)
        $fell(drive_o) |-> rst_o); // R3
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic            clk_i,
    input  logic            por_ni,
    input  req_t            ev_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_mask_i,
    output logic [NSRC-1:0] cause_o
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
    } cause_t;

    cause_t cause_d, cause_q;
    logic   any_set;

    always_comb begin
        cause_d = cause_q;
        if (clr_we_i) cause_d.flags = cause_q.flags & ~clr_mask_i;
        if (ev_i.pin)  cause_d.flags[SRC_PIN]  = 1'b1;
        if (ev_i.cmon) cause_d.flags[SRC_CMON] = 1'b1;
        if (ev_i.wdog) cause_d.flags[SRC_WDOG] = 1'b1;
        any_set = ev_i.pin | ev_i.cmon | ev_i.wdog;
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) cause_q <= '{flags: NSRC'(1) << SRC_POR};
        else         cause_q <= cause_d;
    end

    assign cause_o = cause_q.flags;

    AST_WDOG_FLAG_SET: assert property (@(posedge clk_i) disable iff (!por_ni)
        ev_i.wdog |=> cause_o[SRC_WDOG]); // R5
    AST_FLAGS_STABLE: assert property (@(posedge clk_i) disable iff (!por_ni)
        (!clr_we_i && !any_set) |=> $stable(cause_o)); // R9
    AST_POR_FLAG_KEPT: assert property (@(posedge clk_i) disable iff (!por_ni)
        (cause_o[SRC_POR] && !(clr_we_i && clr_mask_i[SRC_POR])) |=> cause_o[SRC_POR]); // R10
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC   = 512,
    parameter int WAIT_CYC    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            por_ni,
    input  logic            pin_i,
    output logic            pin_drive_o,
    input  logic            wdog_i,
    input  logic            cmon_fail_i,
    input  logic            osc_en_i,
    input  logic            full_stop_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_mask_i,
    output logic [NSRC-1:0] cause_o,
    output logic            rst_o
);
    logic pin_hi;
    logic idle;
    logic start;
    req_t req;

    rstseq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .por_ni   (por_ni),
        .pin_i    (pin_i),
        .pin_hi_o (pin_hi)
    );

    rstseq_req u_req (
        .idle_i      (idle),
        .pin_hi_i    (pin_hi),
        .wdog_i      (wdog_i),
        .cmon_fail_i (cmon_fail_i),
        .osc_en_i    (osc_en_i),
        .full_stop_i (full_stop_i),
        .req_o       (req),
        .start_o     (start)
    );

    rstseq_fsm #(.DRIVE_CYC(DRIVE_CYC), .WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk_i    (clk_i),
        .por_ni   (por_ni),
        .start_i  (start),
        .pin_hi_i (pin_hi),
        .idle_o   (idle),
        .drive_o  (pin_drive_o),
        .rst_o    (rst_o)
    );

    rstseq_cause u_cause (
        .clk_i      (clk_i),
        .por_ni     (por_ni),
        .ev_i       (req),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .cause_o    (cause_o)
    );

    AST_CMON_GATED: assert property (@(posedge clk_i) disable iff (!por_ni)
        (idle && pin_hi && !wdog_i && cmon_fail_i && (!osc_en_i || full_stop_i))
        |=> !rst_o); // R6
endmodule

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_drive;
    logic       ext_low = 1'b0;
    logic       wdog = 1'b0, cmon = 1'b0, osc_en = 1'b0, fstop = 1'b0;
    logic       clr_we = 1'b0;
    logic [3:0] clr_mask = 4'h0;
    logic [3:0] cause;
    logic       rst;
    logic       pin;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    assign pin = (pin_drive | ext_low) ? 1'b0 : 1'b1;

    rstseq_top uut (
        .clk_i(clk), .por_ni(por_n), .pin_i(pin), .pin_drive_o(pin_drive),
        .wdog_i(wdog), .cmon_fail_i(cmon), .osc_en_i(osc_en), .full_stop_i(fstop),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask), .cause_o(cause), .rst_o(rst)
    );

    // src: 0 watchdog, 1 clock monitor, 2 pin
    typedef struct packed {
        logic [1:0] src;
        logic       osc;
        logic       fs;
        logic [1:0] hold;
        logic       exp_rst;
        logic [3:0] exp_cause;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 4'b1000},
        '{2'd1, 1'b1, 1'b0, 2'd1, 1'b1, 4'b0100},
        '{2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 4'b0000},
        '{2'd1, 1'b1, 1'b1, 2'd1, 1'b0, 4'b0000},
        '{2'd2, 1'b0, 1'b0, 2'd3, 1'b1, 4'b0010},
        '{2'd2, 1'b0, 1'b0, 2'd1, 1'b1, 4'b0010}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_mask = 4'hF;
        step(1);
        clr_we = 1'b0; clr_mask = 4'h0;
    endtask

    initial begin
        step(200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 R10: reset state
        step(3);
        check("R1 rst", rst, 1);
        check("R1 drive", pin_drive, 1);
        check("R10 cause", cause, 4'b0001);

        // R2 R3: exact timing after power-on release
        por_n = 1'b1;
        step(511);
        check("R3 drive before 512", pin_drive, 1);
        step(1);
        check("R3 drive off at 512", pin_drive, 0);
        check("R3 rst in wait", rst, 1);
        step(255);
        check("R2 rst at 767", rst, 1);
        step(1);
        check("R2 rst off at 768", rst, 0);

        // table of single-source stimuli: R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            clear_all();
            osc_en = TBL[i].osc; fstop = TBL[i].fs;
            case (TBL[i].src)
                2'd0: wdog = 1'b1;
                2'd1: cmon = 1'b1;
                default: ext_low = 1'b1;
            endcase
            step(int'(TBL[i].hold));
            wdog = 1'b0; cmon = 1'b0; ext_low = 1'b0;
            step(3 - int'(TBL[i].hold));
            check($sformatf("R5/R6/R7 vec%0d rst", i), rst, TBL[i].exp_rst);
            check($sformatf("R5/R6/R7 vec%0d cause", i), cause, TBL[i].exp_cause);
            step(800);
            check($sformatf("R2 vec%0d rst done", i), rst, 0);
            osc_en = 1'b0; fstop = 1'b0;
        end

        // R5 R2: watchdog exact timing
        wdog = 1'b1; step(1); wdog = 1'b0;
        check("R5 rst on edge", rst, 1);
        step(511);
        check("R3 wdog drive at 511", pin_drive, 1);
        step(1);
        check("R3 wdog drive off", pin_drive, 0);
        step(255);
        check("R2 wdog rst at 767", rst, 1);
        step(1);
        check("R2 wdog rst off", rst, 0);

        // R8: restart mid-sequence by clock monitor
        wdog = 1'b1; step(1); wdog = 1'b0;
        step(300);
        osc_en = 1'b1; cmon = 1'b1; step(1); cmon = 1'b0; osc_en = 1'b0;
        step(511);
        check("R8 drive after restart", pin_drive, 1);
        step(1);
        check("R8 drive off after restart", pin_drive, 0);
        step(256);
        check("R8 rst off after restart", rst, 0);

        // R4 R7: long external hold stretches, no retrigger
        clear_all();
        ext_low = 1'b1;
        step(3);
        check("R7 pin start", rst, 1);
        check("R7 pin cause", cause, 4'b0010);
        step(1000);
        check("R4 stretched rst", rst, 1);
        check("R4 pin released by block", pin_drive, 0);
        ext_low = 1'b0;
        step(2);
        check("R4 rst before sync", rst, 1);
        step(1);
        check("R4 rst off 3rd edge", rst, 0);
        check("R7 no retrigger", pin_drive, 0);

        // R9: masked clear and set-wins
        clear_all();
        wdog = 1'b1; step(1); wdog = 1'b0;
        step(800);
        ext_low = 1'b1; step(1); ext_low = 1'b0;
        step(800);
        check("R9 both flags", cause, 4'b1010);
        clr_we = 1'b1; clr_mask = 4'b0010; step(1);
        clr_we = 1'b0; clr_mask = 4'h0;
        check("R9 masked clear", cause, 4'b1000);
        clr_we = 1'b1; clr_mask = 4'b1000; wdog = 1'b1; step(1);
        clr_we = 1'b0; clr_mask = 4'h0; wdog = 1'b0;
        check("R9 set wins", cause, 4'b1000);
        step(800);

        // R10: power-on wipes other flags
        por_n = 1'b0;
        step(2);
        check("R10 por wipes", cause, 4'b0001);
        check("R1 rst in por", rst, 1);
        por_n = 1'b1;
        step(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule